// File: doc/BRIEF.md
# Half-to-Single Precision Floating-Point Widener

This block widens a 16-bit floating-point operand into the 32-bit single-precision value that equals it. It also reports the class of the operand and two per-operation exception flags. One operand is accepted on every clock in which `in_valid` is high. The result, the class and the flags come out of one register stage, so they appear one clock later together with `out_valid`.

Two mode inputs go with each operand. `alt_fmt` selects an alternative 16-bit encoding in which the all-ones exponent holds ordinary normalized numbers instead of infinities and NaNs. `ftz_en` replaces a subnormal operand with a zero of the same sign and raises an input-subnormal flag. When `ftz_en` is low, a subnormal operand is normalized exactly. Every 16-bit value has an exact single-precision equivalent, so no rounding takes place.

Top module: `hcvt_top`

## Requirements
- R1: A normal operand (exponent field 1..30, or 31 when `alt_fmt`=1) gives single exponent = half exponent + 112. Its 10 fraction bits fill result bits [22:13] and bits [12:0] are zero. The sign is copied to bit 31.
- R2: An operand whose exponent and fraction fields are both zero gives a zero with the same sign (0x00000000 or 0x80000000) and class code 0.
- R3: With `alt_fmt`=0, exponent field 31 with a zero fraction gives an infinity of the same sign (0x7F800000 or 0xFF800000) and class code 3.
- R4: With `alt_fmt`=0, exponent field 31 with a nonzero fraction is a NaN. Input fraction bit 9 set means quiet (class 4) and clear means signaling (class 5). The result keeps the sign, has exponent 0xFF and result bit 22 set, carries input fraction bits [8:0] into result bits [21:13], and has zeros below. `out_invalid` is 1 exactly for a signaling operand.
- R5: With `alt_fmt`=1, exponent field 31 is a normal number (-1)^S x 2^16 x 1.fraction and has class code 2. 0x7FFF gives 131008 = 0x47FFE000 and 0x7C00 gives 0x47800000. This mode never reports class 3, 4 or 5.
- R6: With `ftz_en`=0, a subnormal operand (exponent 0, fraction nonzero) is normalized. If L is the number of leading zeros of the 10-bit fraction, the single exponent is 112 - L and the fraction bits below the leading one are shifted into the top of the result fraction. Examples: 0x0001 gives 0x33800000, 0x8200 gives 0xB8000000, 0x03FF gives 0x387FC000.
- R7: With `ftz_en`=1, a subnormal operand gives a zero of the same sign and sets `out_idenorm`. `out_idenorm` is 0 for every other operand or mode.
- R8: Class code 1 marks a subnormal operand, whether it is flushed or not. The class codes are 0 zero, 1 subnormal, 2 normal, 3 infinity, 4 quiet NaN and 5 signaling NaN.
- R9: `out_word`, `out_class` and the flags belong to the operand accepted one clock earlier. `out_valid` equals `in_valid` delayed by one clock. Both flags are 0 in every cycle in which `out_valid` is 0. Back-to-back operands each produce their own result.
- R10: While `rst_n` is low, `out_valid`, `out_invalid` and `out_idenorm` are 0, even if `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operand present this cycle |
| in_half | input | 16 | Operand: sign [15], exponent [14:10], fraction [9:0] |
| alt_fmt | input | 1 | 1 = alternative encoding with no infinities or NaNs |
| ftz_en | input | 1 | 1 = flush subnormal operands to signed zero |
| out_valid | output | 1 | Result present this cycle |
| out_word | output | 32 | Single-precision result |
| out_class | output | 3 | Class code of the operand |
| out_invalid | output | 1 | Signaling NaN was quietened |
| out_idenorm | output | 1 | Subnormal operand was flushed |

## Verification
Directed operands cover each class: ±1.0, ±2.0 and the largest finite value for the normal path, signed zeros, both infinities, and quiet and signaling NaNs with distinct payloads. The same all-ones exponent patterns are then repeated with the alternative encoding, which shows whether the mode bit really moves them onto the normal path. Subnormals with the leading one at the top, at the bottom and with all fraction bits set are sent with flushing off and then on. These cases separate an exact normalization from a wrong shift count, and a flushed zero from one that loses its sign. Back-to-back operands and idle cycles check that each result is paired with its own operand and that the flags are cleared when no result is valid.

// File: rtl/hcvt_pkg.sv
package hcvt_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } hcls_e;
endpackage

// File: rtl/hcvt_unpack.sv
module hcvt_unpack
  import hcvt_pkg::*;
#(
  parameter int HEW = 5,
  parameter int HFW = 10
) (
  input  logic [HEW+HFW:0] half_i,
  input  logic             alt_i,
  output logic             sign_o,
  output logic [HEW-1:0]   exp_o,
  output logic [HFW-1:0]   frac_o,
  output hcls_e            cls_o
);
  localparam logic [HEW-1:0] EXP_TOP = '1;

  logic exp_zero, exp_full, frac_zero;

  always_comb begin
    sign_o    = half_i[HEW+HFW];
    exp_o     = half_i[HEW+HFW-1:HFW];
    frac_o    = half_i[HFW-1:0];
    exp_zero  = (exp_o == '0);
    exp_full  = (exp_o == EXP_TOP);
    frac_zero = (frac_o == '0);
    if (exp_zero) begin
      cls_o = frac_zero ? CLS_ZERO : CLS_SUB;
    end else if (exp_full && !alt_i) begin
      if (frac_zero)             cls_o = CLS_INF;
      else if (frac_o[HFW-1])    cls_o = CLS_QNAN;
      else                       cls_o = CLS_SNAN;
    end else begin
      cls_o = CLS_NORM;
    end
  end
endmodule

// File: rtl/hcvt_lzc.sv
module hcvt_lzc #(
  parameter int W  = 10,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/hcvt_pack.sv
module hcvt_pack
  import hcvt_pkg::*;
#(
  parameter int HEW = 5,
  parameter int HFW = 10,
  parameter int SEW = 8,
  parameter int SFW = 23,
  localparam int CW = $clog2(HFW + 1)
) (
  input  hcls_e              cls_i,
  input  logic               sign_i,
  input  logic [HEW-1:0]     exp_i,
  input  logic [HFW-1:0]     frac_i,
  input  logic [CW-1:0]      lz_i,
  input  logic               ftz_i,
  output logic [SEW+SFW:0]   word_o,
  output logic               inv_o,
  output logic               idn_o
);
  localparam int HBIAS = (1 << (HEW - 1)) - 1;
  localparam int SBIAS = (1 << (SEW - 1)) - 1;
  localparam logic [SEW-1:0] ADJ   = SEW'(SBIAS - HBIAS);
  localparam int             PADW  = SFW - HFW;
  localparam logic [SEW-1:0] SEXPF = '1;

  logic [HFW:0]   sh;
  logic [SEW-1:0] e_out;
  logic [SFW-1:0] f_out;

  always_comb begin
    sh    = ({1'b0, frac_i} << lz_i) << 1;
    e_out = '0;
    f_out = '0;
    inv_o = 1'b0;
    idn_o = 1'b0;
    unique case (cls_i)
      CLS_ZERO: ;
      CLS_SUB: begin
        if (ftz_i) begin
          idn_o = 1'b1;
        end else begin
          e_out = ADJ - SEW'(lz_i);
          f_out = {sh[HFW-1:0], {PADW{1'b0}}};
        end
      end
      CLS_NORM: begin
        e_out = SEW'(exp_i) + ADJ;
        f_out = {frac_i, {PADW{1'b0}}};
      end
      CLS_INF: e_out = SEXPF;
      CLS_QNAN, CLS_SNAN: begin
        e_out = SEXPF;
        f_out = {1'b1, frac_i[HFW-2:0], {PADW{1'b0}}};
        inv_o = (cls_i == CLS_SNAN);
      end
      default: ;
    endcase
    word_o = {sign_i, e_out, f_out};
  end
endmodule

// File: rtl/hcvt_top.sv
module hcvt_top
  import hcvt_pkg::*;
#(
  parameter int HEW = 5,
  parameter int HFW = 10,
  parameter int SEW = 8,
  parameter int SFW = 23,
  localparam int HW = 1 + HEW + HFW,
  localparam int SW = 1 + SEW + SFW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [HW-1:0] in_half,
  input  logic          alt_fmt,
  input  logic          ftz_en,
  output logic          out_valid,
  output logic [SW-1:0] out_word,
  output logic [2:0]    out_class,
  output logic          out_invalid,
  output logic          out_idenorm
);
  localparam int CW = $clog2(HFW + 1);

  logic           u_sign;
  logic [HEW-1:0] u_exp;
  logic [HFW-1:0] u_frac;
  hcls_e          u_cls;
  logic [CW-1:0]  u_lz;
  logic [SW-1:0]  p_word;
  logic           p_inv, p_idn;

  hcvt_unpack #(.HEW(HEW), .HFW(HFW)) u_unpack (
    .half_i(in_half), .alt_i(alt_fmt),
    .sign_o(u_sign), .exp_o(u_exp), .frac_o(u_frac), .cls_o(u_cls)
  );

  hcvt_lzc #(.W(HFW)) u_lzc (.vec_i(u_frac), .cnt_o(u_lz));

  hcvt_pack #(.HEW(HEW), .HFW(HFW), .SEW(SEW), .SFW(SFW)) u_pack (
    .cls_i(u_cls), .sign_i(u_sign), .exp_i(u_exp), .frac_i(u_frac),
    .lz_i(u_lz), .ftz_i(ftz_en),
    .word_o(p_word), .inv_o(p_inv), .idn_o(p_idn)
  );

  // next-state logic
  logic vld_d, inv_d, idn_d;
  always_comb begin
    vld_d = in_valid;
    inv_d = in_valid & p_inv;
    idn_d = in_valid & p_idn;
  end

  // control registers with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_invalid <= 1'b0;
      out_idenorm <= 1'b0;
    end else begin
      out_valid   <= vld_d;
      out_invalid <= inv_d;
      out_idenorm <= idn_d;
    end
  end

  // datapath registers, loaded only when an operand is accepted
  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_word  <= p_word;
      out_class <= u_cls;
    end
  end

  // R9: strobe follows input valid with one cycle of latency
  a_r9_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_idle_lat: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R9: flags are quiet when no result is presented
  a_r9_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_invalid && !out_idenorm));
  // R4: a signaling NaN comes out quiet and flagged
  a_r4_snan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 3'(CLS_SNAN)) |-> (out_word[SFW-1] && out_invalid));
  // R7: flushing yields a signed zero and the flag
  a_r7_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ftz_en && in_half[HW-2:HFW] == '0 && in_half[HFW-1:0] != '0)
    |=> (out_word[SW-2:0] == '0 && out_idenorm
         && out_word[SW-1] == $past(in_half[HW-1])));
  // R5: alternative encoding has no special classes
  a_r5_alt_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && alt_fmt) |=> (out_class <= 3'(CLS_NORM) && !out_invalid));
endmodule

// File: tb/sim_hcvt_top.sv
module sim_hcvt_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_half;
  logic        alt_fmt, ftz_en;
  logic        out_valid;
  logic [31:0] out_word;
  logic [2:0]  out_class;
  logic        out_invalid, out_idenorm;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  hcvt_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_half(in_half),
    .alt_fmt(alt_fmt), .ftz_en(ftz_en), .out_valid(out_valid),
    .out_word(out_word), .out_class(out_class),
    .out_invalid(out_invalid), .out_idenorm(out_idenorm)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  // one operand, checked one clock later
  task automatic conv(input string tag, input logic [15:0] h, input logic alt,
                      input logic ftz, input logic [31:0] ew, input logic [2:0] ec,
                      input logic ei, input logic ed);
    @(negedge clk);
    in_valid = 1'b1; in_half = h; alt_fmt = alt; ftz_en = ftz;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R9 valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " word"}, out_word, ew);
    chk({tag, " R8 class"}, {29'd0, out_class}, {29'd0, ec});
    chk({tag, " R4 invalid"}, {31'd0, out_invalid}, {31'd0, ei});
    chk({tag, " R7 idenorm"}, {31'd0, out_idenorm}, {31'd0, ed});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b1; in_half = 16'h7C01; alt_fmt = 1'b0; ftz_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R10 flags in reset", {30'd0, out_invalid, out_idenorm}, 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 valid after reset", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_normal;
    conv("R1 one",   16'h3C00, 0, 0, 32'h3F800000, 3'd2, 0, 0);
    conv("R1 neg2",  16'hC000, 0, 0, 32'hC0000000, 3'd2, 0, 0);
    conv("R1 max",   16'h7BFF, 0, 1, 32'h477FE000, 3'd2, 0, 0);
    conv("R1 smin",  16'h0400, 0, 0, 32'h38800000, 3'd2, 0, 0);
  endtask

  task automatic t_zero;
    conv("R2 pzero", 16'h0000, 0, 1, 32'h00000000, 3'd0, 0, 0);
    conv("R2 nzero", 16'h8000, 1, 0, 32'h80000000, 3'd0, 0, 0);
  endtask

  task automatic t_special;
    conv("R3 pinf",  16'h7C00, 0, 0, 32'h7F800000, 3'd3, 0, 0);
    conv("R3 ninf",  16'hFC00, 0, 0, 32'hFF800000, 3'd3, 0, 0);
    conv("R4 qnan",  16'h7E00, 0, 0, 32'h7FC00000, 3'd4, 0, 0);
    conv("R4 qpay",  16'hFF01, 0, 0, 32'hFFE02000, 3'd4, 0, 0);
    conv("R4 snan",  16'h7C01, 0, 0, 32'h7FC02000, 3'd5, 1, 0);
    conv("R4 spay",  16'hFD55, 0, 1, 32'hFFEAA000, 3'd5, 1, 0);
  endtask

  task automatic t_alt;
    conv("R5 altmax", 16'h7FFF, 1, 0, 32'h47FFE000, 3'd2, 0, 0);
    conv("R5 alt64k", 16'h7C00, 1, 0, 32'h47800000, 3'd2, 0, 0);
    conv("R5 altneg", 16'hFE00, 1, 0, 32'hC7C00000, 3'd2, 0, 0);
    conv("R5 altnorm",16'h3C00, 1, 0, 32'h3F800000, 3'd2, 0, 0);
  endtask

  task automatic t_sub;
    conv("R6 tiny",  16'h0001, 0, 0, 32'h33800000, 3'd1, 0, 0);
    conv("R6 top",   16'h8200, 0, 0, 32'hB8000000, 3'd1, 0, 0);
    conv("R6 full",  16'h03FF, 1, 0, 32'h387FC000, 3'd1, 0, 0);
    conv("R7 pflush",16'h03FF, 0, 1, 32'h00000000, 3'd1, 0, 1);
    conv("R7 nflush",16'h8001, 1, 1, 32'h80000000, 3'd1, 0, 1);
  endtask

  task automatic t_stream;
    @(negedge clk);
    in_valid = 1'b1; in_half = 16'h7C01; alt_fmt = 1'b0; ftz_en = 1'b0;
    @(negedge clk);
    in_half = 16'h8001; ftz_en = 1'b1;
    chk("R9 b2b first word", out_word, 32'h7FC02000);
    chk("R9 b2b first inv", {31'd0, out_invalid}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0; in_half = 16'h7C01; ftz_en = 1'b0;
    chk("R9 b2b second word", out_word, 32'h80000000);
    chk("R9 b2b second flags", {30'd0, out_invalid, out_idenorm}, 32'd1);
    @(negedge clk);
    chk("R9 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R9 idle flags", {30'd0, out_invalid, out_idenorm}, 32'd0);
    chk("R9 idle hold word", out_word, 32'h80000000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_zero();
    t_special();
    t_alt();
    t_sub();
    t_stream();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule